// File: doc/BRIEF.md
# Dual-Format Serial Link Request Decoder

This block sits on the serial request line that a link-layer controller drives toward a physical-layer arbiter. The line carries one bit per clock and is held at 0 when idle. Each request opens with a start bit of 1, followed by a 3-bit request type sent most significant bit first. Bus-arbitration requests come in two lengths that share the line with no mode pin. The short form is 7 bits and carries a 2-bit speed code. The long form is 8 bits and carries a 3-bit speed code. The decoder emits one registered strobe for each bus request, together with its kind, a normalized 3-bit speed, a concatenation flag and a null-packet command for speeds it cannot serve.

Register read and write requests use the same line. Their type field selects a fixed body length. After the type field the body is only collected and handed off on a separate strobe, and the decoder then returns to idle. Two configuration inputs gate features. One allows accelerated asynchronous arbitration requests. The other allows the multispeed-concatenation flag to pass.

The length ambiguity is settled at the eighth bit position of a bus request. A 1 there must be the start bit of a new request, so the current request is closed as a short one and the new one is parsed at once. A 0 there is read as a zero speed LSB, and it decodes to the same speed that the short form would give.

Top module: `lreq_decoder`

## Requirements
- R1: The line idles at 0. A request starts with a 1, followed by a 3-bit type sent MSB first. The types are 001 fair, 010 priority and 011 accelerated for bus requests, 101 register read and 110 register write. Bus and register strobes never occur in the same cycle.
- R2: A bus request is start, type, one concatenation bit and then a 2-bit speed code sent MSB first. A 7-bit request followed by idle reports speed 000 for code 00 (S100), 010 for code 01 (S200) and 100 for code 10 (S400).
- R3: An 8-bit request carries a third speed bit of 0 in bit position 8. It reports the same 3-bit speed as its 2-bit prefix would, and a reported speed always has LSB 0.
- R4: When a 7-bit bus request is followed at once by a 1 in bit position 8, that bit is the start bit of the next request, and both requests are decoded. This holds when the next request is a register request.
- R5: Speed code 11 (reported as 110, above S400) is still accepted and strobed, with null_pkt_o=1. Every supported speed strobes with null_pkt_o=0.
- R6: An accelerated request is reported as kind 2 only when eaa_en_i is 1 at its decision cycle. Otherwise it is reported as fair, kind 0. Priority is kind 1.
- R7: The concatenation bit (bit position 5) is reported on breq_concat_o only when emc_en_i is 1. Otherwise it reads 0.
- R8: A register read has a 4-bit address body sent MSB first. A register write has a 4-bit address and then 8 data bits, each sent MSB first. Each raises reg_stb_o with reg_wr_o set for a write, and reg_data_o is 0 for a read. The next bit after the body may start a new request.
- R9: Types 000, 100 and 111 produce no strobe. The decoder returns to idle right after the type field.
- R10: Strobes last exactly one clock. A bus strobe is high in the cycle after the bit in position 8 is sampled, and a register strobe is high in the cycle after the last body bit. A synchronous reset, even in the middle of a request, returns the parser to idle with both strobes low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; the line is sampled on the rising edge |
| rst | input | 1 | Synchronous active-high reset |
| ser_i | input | 1 | Serial request line, one bit per clock |
| eaa_en_i | input | 1 | Enables accelerated arbitration requests |
| emc_en_i | input | 1 | Enables the multispeed-concatenation flag |
| breq_stb_o | output | 1 | One-clock strobe for a decoded bus request |
| breq_kind_o | output | 2 | 0 fair, 1 priority, 2 accelerated |
| breq_concat_o | output | 1 | Gated concatenation flag |
| breq_speed_o | output | 3 | Normalized speed: 000 S100, 010 S200, 100 S400 |
| null_pkt_o | output | 1 | Speed above S400; send a data-prefix then data-end with no payload |
| reg_stb_o | output | 1 | One-clock strobe for a register request |
| reg_wr_o | output | 1 | 1 for a write, 0 for a read |
| reg_addr_o | output | 4 | Register address |
| reg_data_o | output | 8 | Write data, 0 on a read |

## Verification
The hardest case to reach is the bit-8 decision when a new request starts directly after a short bus request. That case gets harder when the following request is itself short, or is a register request whose body must not be confused with the speed field. Random bursts therefore draw the idle gap after each frame from 0 to 2 bits and mix all frame kinds, so chains of back-to-back 7-bit requests occur often. Directed cases add a chain of three short requests, a short request straight into a register write, and a reset that cuts a request off midway.

// File: rtl/lreq_pkg.sv
package lreq_pkg;

    typedef enum logic [2:0] {
        RT_RSV0  = 3'b000,
        RT_FAIR  = 3'b001,
        RT_PRIO  = 3'b010,
        RT_ACCEL = 3'b011,
        RT_RSV4  = 3'b100,
        RT_RDREG = 3'b101,
        RT_WRREG = 3'b110,
        RT_RSV7  = 3'b111
    } req_type_e;

    typedef enum logic [1:0] {
        BK_FAIR  = 2'd0,
        BK_PRIO  = 2'd1,
        BK_ACCEL = 2'd2
    } breq_kind_e;

    typedef struct packed {
        breq_kind_e kind;
        logic       concat;
        logic [2:0] code;
    } breq_evt_t;

    localparam logic [2:0] SPD_S100 = 3'b000;
    localparam logic [2:0] SPD_S200 = 3'b010;
    localparam logic [2:0] SPD_S400 = 3'b100;

    function automatic logic is_bus_type(input req_type_e t);
        return (t == RT_FAIR) || (t == RT_PRIO) || (t == RT_ACCEL);
    endfunction

    function automatic breq_kind_e kind_of(input req_type_e t);
        case (t)
            RT_PRIO:  return BK_PRIO;
            RT_ACCEL: return BK_ACCEL;
            default:  return BK_FAIR;
        endcase
    endfunction

    function automatic logic speed_supported(input logic [2:0] c);
        return (c == SPD_S100) || (c == SPD_S200) || (c == SPD_S400);
    endfunction

endpackage

// File: rtl/lreq_parser.sv
module lreq_parser
    import lreq_pkg::*;
#(
    parameter int ADDR_W = 4,
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              ser_i,
    output logic              breq_evt_o,
    output breq_evt_t         breq_o,
    output logic              reg_evt_o,
    output logic              reg_wr_o,
    output logic [ADDR_W-1:0] reg_addr_o,
    output logic [DATA_W-1:0] reg_data_o
);
    localparam int SH_W   = ADDR_W + DATA_W;
    localparam int CNT_W  = $clog2(SH_W + 1);
    localparam int TYPE_W = 3;
    localparam int BODY_W = 3;

    typedef enum logic [2:0] {
        PS_IDLE, PS_TYPE, PS_BODY, PS_LOOK, PS_REG
    } pstate_e;

    pstate_e          st_q, st_d;
    logic [CNT_W-1:0] cnt_q, cnt_d;
    logic [CNT_W-1:0] last_q, last_d;
    logic [SH_W-1:0]  sh_q, sh_d, sh_next;
    req_type_e        typ_q, typ_d;
    logic             wr_q, wr_d;
    req_type_e        typ_now;

    assign sh_next = {sh_q[SH_W-2:0], ser_i};
    assign typ_now = req_type_e'(sh_next[TYPE_W-1:0]);

    always_comb begin
        st_d       = st_q;
        cnt_d      = cnt_q + CNT_W'(1);
        last_d     = last_q;
        sh_d       = sh_next;
        typ_d      = typ_q;
        wr_d       = wr_q;
        breq_evt_o = 1'b0;
        breq_o     = '0;
        reg_evt_o  = 1'b0;
        reg_wr_o   = wr_q;
        reg_addr_o = '0;
        reg_data_o = '0;
        case (st_q)
            PS_IDLE: begin
                cnt_d = '0;
                sh_d  = sh_q;
                if (ser_i) st_d = PS_TYPE;
            end
            PS_TYPE: begin
                if (cnt_q == CNT_W'(TYPE_W - 1)) begin
                    typ_d = typ_now;
                    cnt_d = '0;
                    if (is_bus_type(typ_now)) begin
                        st_d = PS_BODY;
                    end else if (typ_now == RT_RDREG) begin
                        st_d   = PS_REG;
                        wr_d   = 1'b0;
                        last_d = CNT_W'(ADDR_W - 1);
                    end else if (typ_now == RT_WRREG) begin
                        st_d   = PS_REG;
                        wr_d   = 1'b1;
                        last_d = CNT_W'(SH_W - 1);
                    end else begin
                        st_d = PS_IDLE;
                    end
                end
            end
            PS_BODY: begin
                if (cnt_q == CNT_W'(BODY_W - 1)) st_d = PS_LOOK;
            end
            PS_LOOK: begin
                // Position 8: a 1 opens the next request, a 0 is a zero speed LSB.
                // Both close this request with the same speed value.
                breq_evt_o    = 1'b1;
                breq_o.kind   = kind_of(typ_q);
                breq_o.concat = sh_q[2];
                breq_o.code   = {sh_q[1:0], 1'b0};
                cnt_d         = '0;
                st_d          = ser_i ? PS_TYPE : PS_IDLE;
            end
            PS_REG: begin
                if (cnt_q == last_q) begin
                    reg_evt_o = 1'b1;
                    st_d      = PS_IDLE;
                    if (wr_q) begin
                        reg_addr_o = sh_next[SH_W-1:DATA_W];
                        reg_data_o = sh_next[DATA_W-1:0];
                    end else begin
                        reg_addr_o = sh_next[ADDR_W-1:0];
                    end
                end
            end
            default: st_d = PS_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q   <= PS_IDLE;
            cnt_q  <= '0;
            last_q <= '0;
            sh_q   <= '0;
            typ_q  <= RT_RSV0;
            wr_q   <= 1'b0;
        end else begin
            st_q   <= st_d;
            cnt_q  <= cnt_d;
            last_q <= last_d;
            sh_q   <= sh_d;
            typ_q  <= typ_d;
            wr_q   <= wr_d;
        end
    end

endmodule

// File: rtl/lreq_gate.sv
module lreq_gate
    import lreq_pkg::*;
(
    input  breq_evt_t raw_i,
    input  logic      eaa_en_i,
    input  logic      emc_en_i,
    output breq_evt_t gated_o,
    output logic      null_o
);
    always_comb begin
        gated_o        = raw_i;
        if (raw_i.kind == BK_ACCEL && !eaa_en_i) gated_o.kind = BK_FAIR;
        gated_o.concat = raw_i.concat & emc_en_i;
        null_o         = !speed_supported(raw_i.code);
    end
endmodule

// File: rtl/lreq_decoder.sv
module lreq_decoder
    import lreq_pkg::*;
#(
    parameter int ADDR_W = 4,
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              ser_i,
    input  logic              eaa_en_i,
    input  logic              emc_en_i,
    output logic              breq_stb_o,
    output logic [1:0]        breq_kind_o,
    output logic              breq_concat_o,
    output logic [2:0]        breq_speed_o,
    output logic              null_pkt_o,
    output logic              reg_stb_o,
    output logic              reg_wr_o,
    output logic [ADDR_W-1:0] reg_addr_o,
    output logic [DATA_W-1:0] reg_data_o
);
    logic              p_breq_evt;
    breq_evt_t         p_breq;
    logic              p_reg_evt;
    logic              p_reg_wr;
    logic [ADDR_W-1:0] p_reg_addr;
    logic [DATA_W-1:0] p_reg_data;
    breq_evt_t         g_breq;
    logic              g_null;

    lreq_parser #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_parser (
        .clk        (clk),
        .rst        (rst),
        .ser_i      (ser_i),
        .breq_evt_o (p_breq_evt),
        .breq_o     (p_breq),
        .reg_evt_o  (p_reg_evt),
        .reg_wr_o   (p_reg_wr),
        .reg_addr_o (p_reg_addr),
        .reg_data_o (p_reg_data)
    );

    lreq_gate u_gate (
        .raw_i    (p_breq),
        .eaa_en_i (eaa_en_i),
        .emc_en_i (emc_en_i),
        .gated_o  (g_breq),
        .null_o   (g_null)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            breq_stb_o    <= 1'b0;
            breq_kind_o   <= '0;
            breq_concat_o <= 1'b0;
            breq_speed_o  <= '0;
            null_pkt_o    <= 1'b0;
            reg_stb_o     <= 1'b0;
            reg_wr_o      <= 1'b0;
            reg_addr_o    <= '0;
            reg_data_o    <= '0;
        end else begin
            breq_stb_o <= p_breq_evt;
            reg_stb_o  <= p_reg_evt;
            if (p_breq_evt) begin
                breq_kind_o   <= g_breq.kind;
                breq_concat_o <= g_breq.concat;
                breq_speed_o  <= g_breq.code;
                null_pkt_o    <= g_null;
            end
            if (p_reg_evt) begin
                reg_wr_o   <= p_reg_wr;
                reg_addr_o <= p_reg_addr;
                reg_data_o <= p_reg_data;
            end
        end
    end

endmodule

// File: rtl/lreq_decoder_chk.sv
module lreq_decoder_chk #(
    parameter int ADDR_W = 4,
    parameter int DATA_W = 8
) (
    input logic              clk,
    input logic              rst,
    input logic              ser_i,
    input logic              eaa_en_i,
    input logic              emc_en_i,
    input logic              breq_stb_o,
    input logic [1:0]        breq_kind_o,
    input logic              breq_concat_o,
    input logic [2:0]        breq_speed_o,
    input logic              null_pkt_o,
    input logic              reg_stb_o,
    input logic              reg_wr_o,
    input logic [ADDR_W-1:0] reg_addr_o,
    input logic [DATA_W-1:0] reg_data_o
);
    AST_BREQ_PULSE: assert property (@(posedge clk) disable iff (rst)
        breq_stb_o |=> !breq_stb_o); // R10
    AST_REG_PULSE: assert property (@(posedge clk) disable iff (rst)
        reg_stb_o |=> !reg_stb_o); // R10
    AST_ONE_STROBE_KIND: assert property (@(posedge clk) disable iff (rst)
        !(breq_stb_o && reg_stb_o)); // R1
    AST_ACCEL_NEEDS_EAA: assert property (@(posedge clk) disable iff (rst)
        (breq_stb_o && breq_kind_o == 2'd2) |-> $past(eaa_en_i)); // R6
    AST_CONCAT_NEEDS_EMC: assert property (@(posedge clk) disable iff (rst)
        (breq_stb_o && breq_concat_o) |-> $past(emc_en_i)); // R7
    AST_SPEED_LSB_ZERO: assert property (@(posedge clk) disable iff (rst)
        breq_stb_o |-> !breq_speed_o[0]); // R3
    AST_NULL_ON_FAST: assert property (@(posedge clk) disable iff (rst)
        breq_stb_o |-> (null_pkt_o == (breq_speed_o == 3'b110))); // R5
    AST_NO_STROBE_AFTER_RESET: assert property (@(posedge clk) disable iff (rst)
        $fell(rst) |-> (!breq_stb_o && !reg_stb_o)); // R10
endmodule

bind lreq_decoder lreq_decoder_chk #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_chk (
    .clk           (clk),
    .rst           (rst),
    .ser_i         (ser_i),
    .eaa_en_i      (eaa_en_i),
    .emc_en_i      (emc_en_i),
    .breq_stb_o    (breq_stb_o),
    .breq_kind_o   (breq_kind_o),
    .breq_concat_o (breq_concat_o),
    .breq_speed_o  (breq_speed_o),
    .null_pkt_o    (null_pkt_o),
    .reg_stb_o     (reg_stb_o),
    .reg_wr_o      (reg_wr_o),
    .reg_addr_o    (reg_addr_o),
    .reg_data_o    (reg_data_o)
);

// File: tb/lreq_decoder_test.sv
`timescale 1ns/1ps
module lreq_decoder_test;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       ser = 1'b0;
    logic       eaa = 1'b0;
    logic       emc = 1'b0;
    logic       breq_stb, breq_concat, null_pkt, reg_stb, reg_wr;
    logic [1:0] breq_kind;
    logic [2:0] breq_speed;
    logic [3:0] reg_addr;
    logic [7:0] reg_data;

    int  checks = 0;
    int  fails  = 0;
    bit  done   = 1'b0;

    logic [20:0] expq[$];
    string       tagq[$];
    bit          bitq[$];

    always #4 clk = ~clk;

    lreq_decoder uut (
        .clk(clk), .rst(rst), .ser_i(ser), .eaa_en_i(eaa), .emc_en_i(emc),
        .breq_stb_o(breq_stb), .breq_kind_o(breq_kind), .breq_concat_o(breq_concat),
        .breq_speed_o(breq_speed), .null_pkt_o(null_pkt), .reg_stb_o(reg_stb),
        .reg_wr_o(reg_wr), .reg_addr_o(reg_addr), .reg_data_o(reg_data)
    );

    function automatic logic [20:0] pk(input bit isr, input bit wr, input logic [3:0] a,
                                       input logic [7:0] d, input logic [1:0] k, input bit c,
                                       input logic [2:0] s, input bit n);
        return {isr, wr, a, d, k, c, s, n};
    endfunction

    task automatic check(input string tag, input bit ok, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic got(input logic [20:0] act);
        if (expq.size() == 0) begin
            check("R9 unexpected strobe", 1'b0, {11'd0, act}, 32'd0);
        end else begin
            logic [20:0] e;
            string t;
            e = expq.pop_front();
            t = tagq.pop_front();
            check(t, act == e, {11'd0, act}, {11'd0, e});
        end
    endtask

    always @(negedge clk) begin
        if (!rst) begin
            if (breq_stb) got(pk(1'b0, 1'b0, 4'd0, 8'd0, breq_kind, breq_concat, breq_speed, null_pkt));
            if (reg_stb)  got(pk(1'b1, reg_wr, reg_addr, reg_data, 2'd0, 1'b0, 3'd0, 1'b0));
        end
    end

    // Expected kind: accelerated falls back to fair without eaa (R6)
    function automatic logic [1:0] exp_kind(input logic [2:0] t);
        if (t == 3'b010) return 2'd1;
        if (t == 3'b011) return eaa ? 2'd2 : 2'd0;
        return 2'd0;
    endfunction

    task automatic add_zeros(input int n);
        for (int i = 0; i < n; i++) bitq.push_back(1'b0);
    endtask

    task automatic add_breq(input logic [2:0] t, input bit cc, input logic [1:0] s,
                            input bit ext, input int gap, input string tag);
        bitq.push_back(1'b1);
        for (int i = 2; i >= 0; i--) bitq.push_back(t[i]);
        bitq.push_back(cc);
        bitq.push_back(s[1]);
        bitq.push_back(s[0]);
        if (ext) bitq.push_back(1'b0);
        add_zeros(gap);
        expq.push_back(pk(1'b0, 1'b0, 4'd0, 8'd0, exp_kind(t), cc & emc, {s, 1'b0}, s == 2'b11));
        tagq.push_back(tag);
    endtask

    task automatic add_reg(input bit wr, input logic [3:0] a, input logic [7:0] d,
                           input int gap, input string tag);
        bitq.push_back(1'b1);
        bitq.push_back(1'b1);
        bitq.push_back(wr ? 1'b1 : 1'b0);
        bitq.push_back(wr ? 1'b0 : 1'b1);
        for (int i = 3; i >= 0; i--) bitq.push_back(a[i]);
        if (wr) for (int i = 7; i >= 0; i--) bitq.push_back(d[i]);
        add_zeros(gap);
        expq.push_back(pk(1'b1, wr, a, wr ? d : 8'd0, 2'd0, 1'b0, 3'd0, 1'b0));
        tagq.push_back(tag);
    endtask

    task automatic add_rsv(input logic [2:0] t, input int gap);
        bitq.push_back(1'b1);
        for (int i = 2; i >= 0; i--) bitq.push_back(t[i]);
        add_zeros(gap);
    endtask

    task automatic send_bit(input bit b);
        @(negedge clk);
        ser = b;
    endtask

    task automatic flush(input int tail);
        while (bitq.size() > 0) send_bit(bitq.pop_front());
        for (int i = 0; i < tail; i++) send_bit(1'b0);
    endtask

    initial begin
        void'($urandom(32'h5EED_0042));
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        check("R10 reset strobes low", !breq_stb && !reg_stb, {30'd0, breq_stb, reg_stb}, 32'd0);
        check("R10 reset fields clear", breq_speed == 3'd0 && reg_addr == 4'd0,
              {25'd0, breq_speed, reg_addr}, 32'd0);

        // R2 legacy speeds, R5 over-speed
        add_breq(3'b001, 1'b0, 2'b00, 1'b0, 2, "R2 legacy S100");
        add_breq(3'b001, 1'b0, 2'b01, 1'b0, 2, "R2 legacy S200");
        add_breq(3'b010, 1'b0, 2'b10, 1'b0, 2, "R2 legacy S400");
        add_breq(3'b001, 1'b0, 2'b11, 1'b0, 2, "R5 legacy over-speed null packet");
        // R3 extended
        add_breq(3'b001, 1'b0, 2'b01, 1'b1, 0, "R3 extended S200");
        add_breq(3'b010, 1'b0, 2'b10, 1'b1, 1, "R3 extended S400");
        add_breq(3'b001, 1'b0, 2'b11, 1'b1, 1, "R5 extended over-speed null packet");
        // R4 chain of short requests then a register write
        add_breq(3'b001, 1'b0, 2'b00, 1'b0, 0, "R4 back-to-back first");
        add_breq(3'b010, 1'b0, 2'b01, 1'b0, 0, "R4 back-to-back second");
        add_breq(3'b001, 1'b0, 2'b10, 1'b0, 0, "R4 back-to-back third");
        add_reg(1'b1, 4'hA, 8'h5C, 0, "R4 short request then register write");
        add_reg(1'b0, 4'h3, 8'h00, 2, "R8 register read");
        // R9 reserved types
        add_rsv(3'b000, 0);
        add_rsv(3'b100, 1);
        add_rsv(3'b111, 0);
        add_breq(3'b001, 1'b0, 2'b01, 1'b1, 2, "R9 decoder idle after reserved type");
        // R6 and R7 with features off
        add_breq(3'b011, 1'b1, 2'b00, 1'b0, 2, "R6 R7 accelerated and concat gated off");
        flush(12);
        eaa = 1'b1;
        emc = 1'b1;
        add_breq(3'b011, 1'b1, 2'b10, 1'b1, 1, "R6 R7 accelerated and concat enabled");
        flush(12);

        // R10 strobe timing: high one cycle after bit position 8, then low
        begin
            bit fr[8] = '{1'b1, 1'b0, 1'b0, 1'b1, 1'b0, 1'b0, 1'b1, 1'b0};
            add_breq(3'b001, 1'b0, 2'b01, 1'b1, 0, "R10 timed request");
            bitq.delete();
            for (int i = 0; i < 8; i++) send_bit(fr[i]);
            @(negedge clk);
            ser = 1'b0;
            check("R10 strobe in cycle after bit 8", breq_stb == 1'b1, {31'd0, breq_stb}, 32'd1);
            @(negedge clk);
            check("R10 strobe lasts one clock", breq_stb == 1'b0, {31'd0, breq_stb}, 32'd0);
            flush(4);
        end

        // R10 reset in the middle of a request
        send_bit(1'b1); send_bit(1'b0); send_bit(1'b0); send_bit(1'b1); send_bit(1'b0);
        @(negedge clk);
        rst = 1'b1;
        ser = 1'b1;
        repeat (2) @(negedge clk);
        rst = 1'b0;
        ser = 1'b0;
        check("R10 strobes low after mid-frame reset", !breq_stb && !reg_stb,
              {30'd0, breq_stb, reg_stb}, 32'd0);
        add_breq(3'b010, 1'b0, 2'b00, 1'b0, 2, "R10 decode after mid-frame reset");
        flush(10);

        // Random bursts
        for (int b = 0; b < 40; b++) begin
            eaa = 1'($urandom % 2);
            emc = 1'($urandom % 2);
            for (int f = 0; f < 20; f++) begin
                int r, gap;
                r = int'($urandom % 10);
                gap = int'($urandom % 3);
                if (r < 6) begin
                    logic [2:0] t;
                    logic [1:0] s;
                    bit cc, ext;
                    string tg;
                    t = 3'(1 + ($urandom % 3));
                    s = 2'($urandom % 4);
                    cc = 1'($urandom % 2);
                    ext = 1'($urandom % 2);
                    if (s == 2'b11) tg = "R5 random over-speed";
                    else if (!ext && gap == 0) tg = "R4 random back-to-back";
                    else if (t == 3'b011) tg = "R6 random accelerated";
                    else if (cc) tg = "R7 random concat";
                    else if (ext) tg = "R3 random extended";
                    else tg = "R2 random legacy";
                    add_breq(t, cc, s, ext, gap, tg);
                end else if (r < 9) begin
                    add_reg(1'($urandom % 2), 4'($urandom), 8'($urandom), gap, "R8 random register");
                end else begin
                    logic [2:0] rt;
                    case ($urandom % 3)
                        0: rt = 3'b000;
                        1: rt = 3'b100;
                        default: rt = 3'b111;
                    endcase
                    add_rsv(rt, gap);
                end
            end
            flush(14);
        end

        repeat (10) @(negedge clk);
        check("R1 every expected request was strobed", expq.size() == 0, expq.size(), 32'd0);
        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL R10 watchdog expired actual=hung expected=finished");
            $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
            $finish;
        end
    end

endmodule